// File: doc/BRIEF.md
# Threshold-Interrupt Receive Character Queue

This block is a small first-in first-out store placed between the serial receive shifter of an asynchronous receiver and the processor bus that consumes received characters. When the shifter finishes a character, it presents the character with a one-cycle transfer strobe. The queue keeps up to four characters and delivers them to the bus oldest first, through a valid/ready read port.

A two-bit interrupt mode chooses how full the queue must be before an accepted character raises the interrupt flag: any level, three or more, or completely full. The test is made only when a character enters the queue, and it uses the fill level after any read in the same cycle. The flag is sticky until software clears it. A character that arrives when no slot can be freed is dropped and raises a sticky overrun flag. The block also reports whether the shifter is idle and whether unread data remains.

The receive side has no back-pressure, because a shifter cannot be stalled: `in_valid` is a strobe, and a strobe that cannot be stored is lost. On the read side `rd_valid` means a character is presented and `rd_ready` takes it. A read is accepted in any cycle where both are high. Raising `rd_ready` while `rd_valid` is low does nothing.

Top module: `rxq_top`

## Requirements
- R1: The queue holds up to 4 characters and returns them oldest first. `rd_data` shows the oldest unread character, and `rd_valid` is high exactly while at least one unread character remains.
- R2: With `irq_mode` 2'b00 or 2'b01, every accepted transfer sets `irq_flag` in the following cycle, whatever the fill level.
- R3: With `irq_mode` 2'b10, an accepted transfer sets `irq_flag` only if the queue then holds 3 or 4 characters.
- R4: With `irq_mode` 2'b11, an accepted transfer sets `irq_flag` only if the queue then holds 4 characters.
- R5: `irq_mode` may change at any cycle, and each transfer is judged under the mode present in its own cycle.
- R6: `irq_flag` is sticky. Reads do not clear it, and an `irq_clr` pulse does. If a qualifying transfer and `irq_clr` fall in the same cycle, the flag ends up set.
- R7: A transfer that arrives while 4 characters are held and no read is accepted is dropped. It sets `overrun`, which stays set until an `ovr_clr` pulse. It never sets `irq_flag`. If a drop and `ovr_clr` coincide, `overrun` stays set.
- R8: A read and a transfer in the same cycle leave the fill level unchanged, and the threshold test uses that level. This also holds when the queue is full, so a full queue plus a read accepts the new character.
- R9: Raising `rd_ready` while the queue is empty changes no state. While the queue is empty, `rd_data` holds the last character read, or 0 if nothing has been read since reset.
- R10: `rx_idle` is high exactly when `shift_busy` is low. It has no effect on `irq_flag`.
- R11: A synchronous active-high `rst` empties the queue, clears `irq_flag` and `overrun`, and sets `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One-cycle transfer strobe from the shifter |
| in_data | input | 8 | Character being transferred |
| shift_busy | input | 1 | Shifter holds a character in progress |
| rd_ready | input | 1 | Bus takes the presented character |
| rd_data | output | 8 | Oldest unread character, or last character read when empty |
| rd_valid | output | 1 | At least one unread character |
| irq_mode | input | 2 | Interrupt threshold selection |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovr_clr | input | 1 | Clears the overrun flag |
| irq_flag | output | 1 | Sticky interrupt flag |
| overrun | output | 1 | Sticky dropped-character flag |
| rx_idle | output | 1 | Shifter has no character in progress |

## Verification
The hardest situation to reach is a full queue that receives a transfer and a read in the same cycle. In that cycle, acceptance depends on the read and the full-threshold test depends on the level after both operations. The stimulus table fills the queue through the three-entry and four-entry thresholds, drops one character to raise `overrun`, and then applies a strobe and a read together. Later rows combine a strobe with `irq_clr`, and a strobe with a read at low fill level, so that the set-over-clear rule and the unchanged-level rule are observed at the flag.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
  typedef enum logic [1:0] {
    IRQ_EACH_A = 2'b00,
    IRQ_EACH_B = 2'b01,
    IRQ_MOST   = 2'b10,
    IRQ_FULL   = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] head_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] slot [DEPTH];

  // Each slot loads only when the write pointer selects it.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot[i] <= '0;
      else if (wr_en && wr_ptr == AW'(i))
        slot[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
    end
  end

  assign head_data = slot[rd_ptr];
endmodule

// File: rtl/rxq_level.sv
`timescale 1ns/1ps
module rxq_level #(
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [LW-1:0] level_q,
  output logic [LW-1:0] level_nxt,
  output logic          full,
  output logic          empty
);
  always_comb begin
    case ({push, pop})
      2'b10:   level_nxt = level_q + 1'b1;
      2'b01:   level_nxt = level_q - 1'b1;
      default: level_nxt = level_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_nxt;
  end

  assign full  = (level_q == LW'(DEPTH));
  assign empty = (level_q == '0);
endmodule

// File: rtl/rxq_irq.sv
`timescale 1ns/1ps
module rxq_irq
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          drop,
  input  logic [LW-1:0] level_nxt,
  input  logic [1:0]    mode,
  input  logic          irq_clr,
  input  logic          ovr_clr,
  output logic          irq_flag,
  output logic          overrun
);
  localparam logic [LW-1:0] THR_ANY  = LW'(1);
  localparam logic [LW-1:0] THR_MOST = LW'(DEPTH - 1);
  localparam logic [LW-1:0] THR_FULL = LW'(DEPTH);

  logic [LW-1:0] thr;
  logic          hit;

  always_comb begin
    case (irq_mode_e'(mode))
      IRQ_MOST: thr = THR_MOST;
      IRQ_FULL: thr = THR_FULL;
      default:  thr = THR_ANY;
    endcase
  end

  assign hit = push && (level_nxt >= thr);

  // A new event takes priority over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (hit)          irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
      if (drop)         overrun  <= 1'b1;
      else if (ovr_clr) overrun  <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_top.sv
`timescale 1ns/1ps
module rxq_top #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          shift_busy,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic [1:0]    irq_mode,
  input  logic          irq_clr,
  input  logic          ovr_clr,
  output logic          irq_flag,
  output logic          overrun,
  output logic          rx_idle
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [LW-1:0] level_q, level_nxt;
  logic          full, empty, pop, push, drop;
  logic [DW-1:0] head_data, last_q;

  assign pop  = rd_ready && !empty;
  assign push = in_valid && (!full || pop);
  assign drop = in_valid && full && !pop;

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr_en(push), .wr_data(in_data),
    .rd_en(pop), .head_data(head_data)
  );

  rxq_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .level_q(level_q), .level_nxt(level_nxt), .full(full), .empty(empty)
  );

  rxq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst(rst), .push(push), .drop(drop), .level_nxt(level_nxt),
    .mode(irq_mode), .irq_clr(irq_clr), .ovr_clr(ovr_clr),
    .irq_flag(irq_flag), .overrun(overrun)
  );

  // Keeps the last character read, shown on rd_data while the queue is empty.
  always_ff @(posedge clk) begin
    if (rst)      last_q <= '0;
    else if (pop) last_q <= head_data;
  end

  assign rd_data  = empty ? last_q : head_data;
  assign rd_valid = !empty;
  assign rx_idle  = !shift_busy;
endmodule

// File: rtl/rxq_checker.sv
`timescale 1ns/1ps
module rxq_checker #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          rd_ready,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic [1:0]    irq_mode,
  input logic          irq_clr,
  input logic          ovr_clr,
  input logic          irq_flag,
  input logic          overrun,
  input logic [LW-1:0] level
);
  assert_level_bound_R1: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  assert_irq_needs_push_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> $past(in_valid));

  assert_full_mode_low_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && irq_mode == 2'b11 && !irq_flag && level < LW'(DEPTH - 1)) |=> !irq_flag);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_clr) |=> irq_flag);

  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun);

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid && rd_ready && !in_valid) |=> (!rd_valid && $stable(rd_data)));

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (!rd_valid && !irq_flag && !overrun && rd_data == '0));
endmodule

bind rxq_top rxq_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .rd_ready(rd_ready),
  .rd_valid(rd_valid), .rd_data(rd_data), .irq_mode(irq_mode),
  .irq_clr(irq_clr), .ovr_clr(ovr_clr), .irq_flag(irq_flag),
  .overrun(overrun), .level(level_q)
);

// File: tb/rxq_top_tb.sv
`timescale 1ns/1ps
module rxq_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       shift_busy = 1'b0;
  logic       rd_ready = 1'b0;
  logic [1:0] irq_mode = 2'b00;
  logic       irq_clr = 1'b0;
  logic       ovr_clr = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid, irq_flag, overrun, rx_idle;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rxq_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .shift_busy(shift_busy), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .irq_mode(irq_mode), .irq_clr(irq_clr),
    .ovr_clr(ovr_clr), .irq_flag(irq_flag), .overrun(overrun),
    .rx_idle(rx_idle)
  );

  // Row: in_valid, in_data, rd_ready, irq_mode, irq_clr, ovr_clr |
  //      expected rd_valid, rd_data, irq_flag, overrun (after the edge)
  localparam int NV = 16;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'hA1, 1'b0, 2'd3, 1'b0, 1'b0,  1'b1, 8'hA1, 1'b0, 1'b0},
    {1'b1, 8'hA2, 1'b0, 2'd3, 1'b0, 1'b0,  1'b1, 8'hA1, 1'b0, 1'b0},
    {1'b1, 8'hA3, 1'b0, 2'd2, 1'b0, 1'b0,  1'b1, 8'hA1, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b0, 2'd2, 1'b1, 1'b0,  1'b1, 8'hA1, 1'b0, 1'b0},
    {1'b1, 8'hA4, 1'b0, 2'd2, 1'b0, 1'b0,  1'b1, 8'hA1, 1'b1, 1'b0},
    {1'b1, 8'hA5, 1'b0, 2'd0, 1'b1, 1'b0,  1'b1, 8'hA1, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1,  1'b1, 8'hA1, 1'b0, 1'b0},
    {1'b1, 8'hA6, 1'b1, 2'd3, 1'b0, 1'b0,  1'b1, 8'hA2, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 1'b0,  1'b1, 8'hA3, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0,  1'b1, 8'hA4, 1'b0, 1'b0},
    {1'b1, 8'hA7, 1'b1, 2'd2, 1'b0, 1'b0,  1'b1, 8'hA6, 1'b0, 1'b0},
    {1'b1, 8'hA8, 1'b1, 2'd1, 1'b0, 1'b0,  1'b1, 8'hA7, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b1, 2'd1, 1'b1, 1'b0,  1'b1, 8'hA8, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0,  1'b0, 8'hA8, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0,  1'b0, 8'hA8, 1'b0, 1'b0},
    {1'b1, 8'hA9, 1'b0, 2'd0, 1'b1, 1'b0,  1'b1, 8'hA9, 1'b1, 1'b0}
  };

  function automatic string row_tag(int i);
    case (i)
      0, 1:    return "R4";
      2, 4:    return "R3";
      3:       return "R6";
      5, 6:    return "R7";
      7, 10:   return "R8";
      8, 9:    return "R1";
      11:      return "R5";
      12:      return "R2";
      13, 14:  return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    @(negedge clk);
    in_valid = 0; rd_ready = 0; irq_clr = 0; ovr_clr = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R11: state after reset
    check("R11", "rd_valid", 32'(rd_valid), 0);
    check("R11", "rd_data",  32'(rd_data),  0);
    check("R11", "irq_flag", 32'(irq_flag), 0);
    check("R11", "overrun",  32'(overrun),  0);
    @(negedge clk) rst = 0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {in_valid, in_data, rd_ready, irq_mode, irq_clr, ovr_clr} = VEC[i][24:11];
      step();
      check(row_tag(i), "row", {21'd0, rd_valid, rd_data, irq_flag, overrun},
            {21'd0, VEC[i][10:0]});
    end
    idle_inputs();

    // R10: idle follows the shifter and never raises the interrupt
    irq_clr = 1;
    step();
    @(negedge clk) irq_clr = 0; shift_busy = 1;
    step(); step();
    check("R10", "rx_idle busy", 32'(rx_idle), 0);
    check("R10", "irq_flag", 32'(irq_flag), 0);
    @(negedge clk) shift_busy = 0;
    #1;
    check("R10", "rx_idle free", 32'(rx_idle), 1);

    // Fill to four (A9 already held), then drop one with a coincident clear
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) in_valid = 1; in_data = 8'hB1 + 8'(k); irq_mode = 2'b00;
      step();
    end
    @(negedge clk) in_data = 8'hC0; ovr_clr = 1;
    step();
    check("R7", "overrun set-wins", 32'(overrun), 1);
    idle_inputs();

    // R1: drain in arrival order
    check("R1", "head A9", 32'(rd_data), 32'hA9);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) rd_ready = 1;
      step();
      check("R1", "order", 32'(rd_data), 32'hB1 + k);
    end
    @(negedge clk);
    step();
    check("R1", "last valid", 32'(rd_valid), 0);
    check("R9", "hold last", 32'(rd_data), 32'hB3);
    idle_inputs();

    // R11: reset in operation
    in_valid = 1; in_data = 8'h5A;
    step();
    @(negedge clk) in_valid = 0; rst = 1;
    step();
    @(negedge clk) rst = 0;
    check("R11", "rd_valid", 32'(rd_valid), 0);
    check("R11", "rd_data",  32'(rd_data),  0);
    check("R11", "flags",    {30'd0, irq_flag, overrun}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule